// File: doc/BRIEF.md
# Stepped Post-Divider with Gated Output

This block divides a fast oscillator clock by a power-of-two ratio chosen by a 2-bit code and drives a clock output with its complement. The output always has a 50% duty cycle. A power-down input adds a further divide by sixteen. That extra factor is not applied in one jump. The block enters it, and leaves it, one doubling at a time, and a slow reference clock paces the steps, so the output frequency moves gradually.

An enable input stops the output cleanly. When the enable is low, the true output rests low and the complement rests high. No high pulse is ever cut short. All ratio changes are loaded at the end of a low phase of the output. A change can come from a new divide code or from a power-down step. Loading at that point means every pulse has the full width of either the old ratio or the new one. With divide by 1 and no extra division, the output is the oscillator clock itself, gated cleanly by the enable.

Top module: `stepped_post_divider`

## Requirements
- R1: The divide code selects the base ratio as follows: 2'b11 gives divide by 1, 2'b00 gives divide by 2, 2'b01 gives divide by 4 and 2'b10 gives divide by 8. A ratio of R gives an output period of R oscillator cycles.
- R2: For every ratio, each high phase and each low phase of the output lasts exactly half the output period.
- R3: While power-down has been held long enough, the ratio is the base ratio times 16 (16, 32, 64 or 128).
- R4: When power-down is raised, the extra factor goes through 2, 4, 8 and 16 in that order. No level is skipped and none repeats.
- R5: When power-down is lowered, the extra factor goes back through 8, 4, 2 and 1 in that order.
- R6: The extra factor changes at most one level per reference-clock edge. Power-down is synchronised to the reference clock before it is used.
- R7: While the enable is low, the true output stays low and the complement stays high. The last high pulse before the stop has full length.
- R8: A new ratio takes effect only at the end of an output low phase. Every high phase has the length of a single ratio.
- R9: With divide by 1 and no extra division, the output follows the oscillator clock while the enable is high. Gating takes effect only while the oscillator clock is low.
- R10: Reset, held active-high, drives the true output low and the complement high, and returns the power-down step level to zero.
- R11: The complement output is always the inverse of the true output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Fast oscillator clock to be divided |
| ref_clk | input | 1 | Slow reference clock that paces the power-down steps |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| n_code | input | 2 | Base divide code (see R1) |
| pwr_dn | input | 1 | Power-down request, asynchronous to both clocks |
| out_en | input | 1 | Output enable, asynchronous to the oscillator clock |
| clk_out | output | 1 | Divided clock, true polarity |
| clk_out_n | output | 1 | Divided clock, complement |

## Verification
The bench measures each high run and each low run of the output in half oscillator cycles. It compares every run with the length predicted from the divide code and the step level. A ratio loaded in the middle of a phase would show up as a high run of a length outside the expected set. An extra or missing power-down step would break the expected run-length sequence of 1, 2, 4, 8, 16 on the way in, and the reverse on the way out. A stepper not paced by the reference clock would finish the climb in much less than three reference periods. The enable is dropped at an arbitrary time. A gate applied in the middle of a pulse would leave a short final high run. The divide-by-1 case is run on its own, because there the output is the clock itself and a gate that changed while the clock was high would clip a half cycle.

// File: rtl/outdiv_pkg.sv
`timescale 1ns/1ps
package outdiv_pkg;

    localparam int NSHIFT_MAX = 3;
    localparam int PD_STEPS   = 4;
    localparam int STEP_W     = $clog2(PD_STEPS + 1);
    localparam int SHIFT_W    = $clog2(NSHIFT_MAX + PD_STEPS + 1);
    localparam int CNT_W      = NSHIFT_MAX + PD_STEPS;

    typedef enum logic [1:0] {
        NDIV_2 = 2'b00,
        NDIV_4 = 2'b01,
        NDIV_8 = 2'b10,
        NDIV_1 = 2'b11
    } ndiv_e;

    // Active configuration, loaded only at a low-phase boundary.
    typedef struct packed {
        logic [SHIFT_W-1:0] shift;  // log2 of the total ratio
        logic               run;    // output allowed to pulse
    } div_cfg_t;

    function automatic logic [1:0] nshift(input logic [1:0] code);
        case (ndiv_e'(code))
            NDIV_1:  nshift = 2'd0;
            NDIV_2:  nshift = 2'd1;
            NDIV_4:  nshift = 2'd2;
            default: nshift = 2'd3;
        endcase
    endfunction

    function automatic logic [STEP_W-1:0] bin2gray(input logic [STEP_W-1:0] b);
        bin2gray = b ^ (b >> 1);
    endfunction

    function automatic logic [STEP_W-1:0] gray2bin(input logic [STEP_W-1:0] g);
        logic [STEP_W-1:0] b;
        b[STEP_W-1] = g[STEP_W-1];
        for (int i = STEP_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        gray2bin = b;
    endfunction

endpackage

// File: rtl/outdiv_sync.sv
`timescale 1ns/1ps
module outdiv_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/outdiv_pd_stepper.sv
`timescale 1ns/1ps
module outdiv_pd_stepper
    import outdiv_pkg::*;
(
    input  logic              ref_clk,
    input  logic              rst,
    input  logic              pwr_dn,
    output logic [STEP_W-1:0] step_gray
);
    logic              pd_s;
    logic [STEP_W-1:0] step;
    logic [STEP_W-1:0] step_nxt;

    outdiv_sync #(.W(1)) pd_sync_i (
        .clk (ref_clk),
        .rst (rst),
        .d   (pwr_dn),
        .q   (pd_s)
    );

    always_comb begin
        step_nxt = step;
        if (pd_s && step != STEP_W'(PD_STEPS))
            step_nxt = step + STEP_W'(1);
        else if (!pd_s && step != '0)
            step_nxt = step - STEP_W'(1);
    end

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            step      <= '0;
            step_gray <= '0;
        end else begin
            step      <= step_nxt;
            step_gray <= bin2gray(step_nxt);
        end
    end

    // R6: the level moves by at most one per reference edge
    p_one_step_r6: assert property (@(posedge ref_clk) disable iff (rst)
        (step == $past(step)) || (step == $past(step) + STEP_W'(1)) ||
        (step + STEP_W'(1) == $past(step)));

    // R3: a full slowdown is held while power-down stays asserted
    p_full_hold_r3: assert property (@(posedge ref_clk) disable iff (rst)
        (pd_s && step == STEP_W'(PD_STEPS)) |=> (step == STEP_W'(PD_STEPS)));
endmodule

// File: rtl/outdiv_core.sv
`timescale 1ns/1ps
module outdiv_core
    import outdiv_pkg::*;
(
    input  logic              vco_clk,
    input  logic              rst,
    input  logic [1:0]        n_code,
    input  logic [STEP_W-1:0] step_gray_s,
    input  logic              en_s,
    output logic              clk_o
);
    div_cfg_t           act;
    logic               q;
    logic               gate;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   half_last;
    logic [SHIFT_W-1:0] shift_req;
    logic               bypass;
    logic               boundary;

    always_comb begin
        shift_req = SHIFT_W'(nshift(n_code)) + SHIFT_W'(gray2bin(step_gray_s));
        bypass    = (act.shift == '0);
        if (bypass)
            half_last = '0;
        else
            half_last = (CNT_W'(1) << (act.shift - SHIFT_W'(1))) - CNT_W'(1);
        boundary  = bypass || (!q && cnt == half_last);
    end

    always_ff @(posedge vco_clk) begin
        if (rst) begin
            act <= '{shift: '0, run: 1'b0};
            q   <= 1'b0;
            cnt <= '0;
        end else if (boundary) begin
            act <= '{shift: shift_req, run: en_s};
            q   <= en_s;
            cnt <= '0;
        end else if (cnt == half_last) begin
            q   <= 1'b0;
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Gate for the undivided case changes only while the clock is low.
    always_ff @(negedge vco_clk) begin
        if (rst) gate <= 1'b0;
        else     gate <= act.run;
    end

    assign clk_o = bypass ? (vco_clk & gate) : q;

    // R8: the ratio is never reloaded during a high phase
    p_change_low_r8: assert property (@(posedge vco_clk) disable iff (rst)
        (!bypass && q) |=> $stable(act.shift));

    // R7: once stopped, the output only pulses again together with a new run
    p_stop_low_r7: assert property (@(posedge vco_clk) disable iff (rst)
        (!act.run && !bypass) |=> (!q || act.run));

    // R2: the phase counter stays inside the current half period
    p_cnt_range_r2: assert property (@(posedge vco_clk) disable iff (rst)
        !bypass |-> (cnt <= half_last));
endmodule

// File: rtl/stepped_post_divider.sv
`timescale 1ns/1ps
module stepped_post_divider
    import outdiv_pkg::*;
(
    input  logic       vco_clk,
    input  logic       ref_clk,
    input  logic       rst,
    input  logic [1:0] n_code,
    input  logic       pwr_dn,
    input  logic       out_en,
    output logic       clk_out,
    output logic       clk_out_n
);
    logic [STEP_W-1:0] step_gray_r;
    logic [STEP_W-1:0] step_gray_v;
    logic              en_v;
    logic              clk_i;

    outdiv_pd_stepper stepper_i (
        .ref_clk   (ref_clk),
        .rst       (rst),
        .pwr_dn    (pwr_dn),
        .step_gray (step_gray_r)
    );

    outdiv_sync #(.W(STEP_W)) step_sync_i (
        .clk (vco_clk),
        .rst (rst),
        .d   (step_gray_r),
        .q   (step_gray_v)
    );

    outdiv_sync #(.W(1)) en_sync_i (
        .clk (vco_clk),
        .rst (rst),
        .d   (out_en),
        .q   (en_v)
    );

    outdiv_core core_i (
        .vco_clk     (vco_clk),
        .rst         (rst),
        .n_code      (n_code),
        .step_gray_s (step_gray_v),
        .en_s        (en_v),
        .clk_o       (clk_i)
    );

    assign clk_out   = clk_i;
    assign clk_out_n = ~clk_i;
endmodule

// File: tb/stepped_post_divider_tb_top.sv
`timescale 1ns/1ps
module stepped_post_divider_tb_top;
    logic       vco_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst     = 1'b1;
    logic [1:0] n_code  = 2'b11;
    logic       pwr_dn  = 1'b0;
    logic       out_en  = 1'b1;
    logic       clk_out;
    logic       clk_out_n;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    // run tracking, lengths in half oscillator cycles
    logic cur_v = 1'b0;
    int   cur_len = 0;
    bit   drop_next = 1'b1;
    int   hi_q[$];
    int   lo_q[$];
    realtime hi_t[$];

    stepped_post_divider dut_i (
        .vco_clk   (vco_clk),
        .ref_clk   (ref_clk),
        .rst       (rst),
        .n_code    (n_code),
        .pwr_dn    (pwr_dn),
        .out_en    (out_en),
        .clk_out   (clk_out),
        .clk_out_n (clk_out_n)
    );

    always #2.5 vco_clk = ~vco_clk;
    always #500 ref_clk = ~ref_clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $realtime);
        end
    endtask

    task automatic sample();
        logic v;
        v = clk_out;
        if (clk_out_n !== ~v) check(1'b0, "R11", int'(clk_out_n), int'(~v));
        if (v === cur_v) begin
            cur_len++;
        end else begin
            if (drop_next) drop_next = 1'b0;
            else if (cur_v) begin hi_q.push_back(cur_len); hi_t.push_back($realtime); end
            else lo_q.push_back(cur_len);
            cur_v = v;
            cur_len = 1;
        end
    endtask

    always @(posedge vco_clk) begin #1.25; sample(); end
    always @(negedge vco_clk) begin #1.25; sample(); end

    task automatic clear_runs();
        hi_q.delete(); lo_q.delete(); hi_t.delete();
        drop_next = 1'b1;
    endtask

    task automatic steady(input logic [1:0] n, input bit pd, input int len, input string req);
        n_code = n;
        pwr_dn = pd;
        #9000;
        clear_runs();
        #(len * 25 + 100);
        check(hi_q.size() >= 2, req, hi_q.size(), 2);
        foreach (hi_q[i]) check(hi_q[i] == len, req, hi_q[i], len);
        foreach (lo_q[i]) check(lo_q[i] == len, "R2", lo_q[i], len);
    endtask

    task automatic check_seq(input int exp[5], input string req);
        int seq[$];
        foreach (hi_q[i]) begin
            if (seq.size() == 0 || seq[seq.size()-1] != hi_q[i]) seq.push_back(hi_q[i]);
        end
        check(seq.size() == 5, req, seq.size(), 5);
        for (int i = 0; i < 5; i++) begin
            if (i < seq.size()) check(seq[i] == exp[i], req, seq[i], exp[i]);
        end
    endtask

    initial begin
        #600000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        realtime t2, t16;
        #2000.3;
        // R10: output held low, complement high during reset
        check(clk_out === 1'b0, "R10", int'(clk_out), 0);
        check(clk_out_n === 1'b1, "R10", int'(clk_out_n), 1);
        #1000 rst = 1'b0;

        // R10 step level zero and R9 undivided clock right after reset
        steady(2'b11, 1'b0, 1, "R9");
        // R1 base ratios
        steady(2'b00, 1'b0, 2, "R1");
        steady(2'b01, 1'b0, 4, "R1");
        steady(2'b10, 1'b0, 8, "R1");
        // R3 full slowdown
        steady(2'b10, 1'b1, 128, "R3");
        steady(2'b00, 1'b1, 32, "R3");

        // R4 entry sequence with divide by 1
        steady(2'b11, 1'b0, 1, "R9");
        clear_runs();
        pwr_dn = 1'b1;
        #9000;
        begin
            int exp_in[5] = '{1, 2, 4, 8, 16};
            check_seq(exp_in, "R4");
        end
        // R6 pacing: from first x2 pulse to first x16 pulse spans three reference steps
        t2 = 0; t16 = 0;
        foreach (hi_q[i]) begin
            if (hi_q[i] == 2 && t2 == 0) t2 = hi_t[i];
            if (hi_q[i] == 16 && t16 == 0) t16 = hi_t[i];
        end
        check((t16 - t2) >= 2500.0, "R6", int'(t16 - t2), 3000);

        // R5 exit sequence
        clear_runs();
        pwr_dn = 1'b0;
        #9000;
        begin
            int exp_out[5] = '{16, 8, 4, 2, 1};
            check_seq(exp_out, "R5");
        end

        // R8 ratio change mid-stream: every high run is a whole period of one ratio
        clear_runs();
        n_code = 2'b10;
        #3000.7;
        n_code = 2'b00;
        #3000;
        foreach (hi_q[i]) check(hi_q[i] == 1 || hi_q[i] == 8 || hi_q[i] == 2, "R8", hi_q[i], 8);

        // R7 enable dropped at an arbitrary time with divide by 4
        steady(2'b01, 1'b0, 4, "R1");
        clear_runs();
        #7.3 out_en = 1'b0;
        #2000;
        foreach (hi_q[i]) check(hi_q[i] == 4, "R7", hi_q[i], 4);
        for (int k = 0; k < 5; k++) begin
            #13.1;
            check(clk_out === 1'b0, "R7", int'(clk_out), 0);
            check(clk_out_n === 1'b1, "R7", int'(clk_out_n), 1);
        end
        out_en = 1'b1;
        steady(2'b01, 1'b0, 4, "R7");

        // R9 enable in the undivided case
        steady(2'b11, 1'b0, 1, "R9");
        clear_runs();
        #3.1 out_en = 1'b0;
        #500;
        foreach (hi_q[i]) check(hi_q[i] == 1, "R9", hi_q[i], 1);
        for (int k = 0; k < 4; k++) begin
            #7.7;
            check(clk_out === 1'b0, "R9", int'(clk_out), 0);
        end
        out_en = 1'b1;
        steady(2'b11, 1'b0, 1, "R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule